// File: doc/BRIEF.md
# Accumulator Processor with Console Ports

This block is a small 8-bit accumulator machine. It runs a two-phase loop of fetch and execute over a 32-byte memory that holds both code and data. It keeps three registers: a program counter, an instruction register and an accumulator. Each instruction byte carries an operation code in its top three bits and a memory address in its low five bits. All arithmetic is 8-bit two's complement and wraps silently.

Two addresses at the top of the memory act as a console. Address 30 is the input location. An operand fetch from it waits for a word on the input handshake instead of reading storage. Address 31 is the output location. A store to it produces a one-cycle strobe carrying the accumulator, and the memory cell is left untouched.

The program is written through a load port while reset is held. Execution starts at address 0 when reset is released. A halted flag reports that the machine has stopped.

Top module: `acc_cpu`

## Requirements
- R1: Each instruction takes exactly two clock cycles, one to fetch and one to execute. The exception is an execute phase stalled by R7. Bits 7:5 of the instruction are the opcode and bits 4:0 are the address. A program of 30 non-stalling instructions ending in HALT raises halted on the 60th rising edge after reset release.
- R2: Every instruction except a taken jump or HALT advances the program counter by one. Opcode 011 does nothing else.
- R3: LOAD (100) copies the operand into the accumulator. ADD (110) and SUB (111) combine the accumulator with the operand modulo 256, so 75+75 gives 0x96 and 0-3 gives 0xFD.
- R4: STORE (101) to any address other than 31 writes the accumulator into that memory byte, and a later read of that byte returns it.
- R5: JUMP (001) always loads the program counter with the address field.
- R6: JPOS (010) loads the program counter with the address field only when the accumulator, read as signed, is greater than zero. A zero or negative accumulator falls through.
- R7: A LOAD, ADD or SUB whose address is 30 takes in_data as its operand. It stalls without progress while in_valid is low. in_ready is high only in the single cycle in which the word is taken, and never while in_valid is low.
- R8: A STORE to address 31 raises out_valid for exactly one cycle, starting at the clock edge that ends its execute phase, with out_data equal to the accumulator. Memory byte 31 keeps its loaded value and can still be read as data.
- R9: HALT (000) stops the machine. halted stays high, no further input is accepted and no further output is produced until reset.
- R10: While rst_n is low, load_en writes load_data into load_addr. Reset clears the program counter, instruction register, accumulator, out_valid and halted, and execution begins at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Program write strobe, used only while rst_n is low |
| load_addr | input | 5 | Program write address |
| load_data | input | 8 | Program write byte |
| in_valid | input | 1 | Console input word is present |
| in_data | input | 8 | Console input word |
| in_ready | output | 1 | Input word taken this cycle |
| out_valid | output | 1 | One-cycle console output strobe |
| out_data | output | 8 | Console output word |
| halted | output | 1 | Machine has executed HALT |

## Verification
The assertions assume three things about the inputs. Once raised, in_valid holds with steady data until in_ready accepts the word. The load port is driven only while rst_n is low. Every program ends in HALT and never runs out of the memory. The directed tasks keep to all of these. They load each program under reset. They offer each console word at a falling edge and withdraw it only after acceptance has been seen. Any stall window is held with in_valid low. The programs are built so that every path, including a wrong branch, reaches a HALT.

// File: rtl/acc_pkg.sv
package acc_pkg;
  parameter int unsigned CPU_DW = 8;
  parameter int unsigned CPU_AW = 5;
  localparam int unsigned CPU_OPW = CPU_DW - CPU_AW;

  typedef enum logic [CPU_OPW-1:0] {
    OP_HALT  = 3'b000,
    OP_JUMP  = 3'b001,
    OP_JPOS  = 3'b010,
    OP_NOP   = 3'b011,
    OP_LOAD  = 3'b100,
    OP_STORE = 3'b101,
    OP_ADD   = 3'b110,
    OP_SUB   = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_HALT  = 2'd2
  } phase_e;

  // modulo-2^DW sum
  function automatic logic [CPU_DW-1:0] wrap_add(input logic [CPU_DW-1:0] a,
                                                 input logic [CPU_DW-1:0] b);
    return a + b;
  endfunction

  // modulo-2^DW difference
  function automatic logic [CPU_DW-1:0] wrap_sub(input logic [CPU_DW-1:0] a,
                                                 input logic [CPU_DW-1:0] b);
    return a - b;
  endfunction

  // strictly greater than zero as signed
  function automatic logic is_positive(input logic [CPU_DW-1:0] v);
    return !v[CPU_DW-1] && (v != '0);
  endfunction

  function automatic logic reads_operand(input op_e op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB);
  endfunction
endpackage

// File: rtl/acc_mem.sv
module acc_mem
  import acc_pkg::*;
#(
  parameter int unsigned DW = CPU_DW,
  parameter int unsigned AW = CPU_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_waddr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH    = 1 << AW;
  localparam logic [AW-1:0] OUT_ADDR = AW'(DEPTH - 1);

  logic [DW-1:0] cells_q [DEPTH];
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  // load port owns the array during reset, the core afterwards
  always_comb begin
    if (!rst_n) begin
      wr_en   = load_en;
      wr_addr = load_addr;
      wr_data = load_data;
    end else begin
      wr_en   = cpu_we;
      wr_addr = cpu_waddr;
      wr_data = cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) cells_q[wr_addr] <= wr_data;
  end

  assign rdata = cells_q[raddr];

  // R8
  out_cell_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |-> (cpu_waddr != OUT_ADDR));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int unsigned DW = CPU_DW
) (
  input  op_e           op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] operand,
  output logic          acc_we,
  output logic [DW-1:0] acc_next,
  output logic          acc_pos
);
  always_comb begin
    acc_we   = 1'b1;
    acc_next = acc;
    unique case (op)
      OP_LOAD: acc_next = operand;
      OP_ADD:  acc_next = wrap_add(acc, operand);
      OP_SUB:  acc_next = wrap_sub(acc, operand);
      default: acc_we   = 1'b0;
    endcase
  end

  assign acc_pos = is_positive(acc);
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int unsigned DW = CPU_DW,
  parameter int unsigned AW = CPU_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          halted
);
  localparam int unsigned DEPTH    = 1 << AW;
  localparam logic [AW-1:0] IN_ADDR  = AW'(DEPTH - 2);
  localparam logic [AW-1:0] OUT_ADDR = AW'(DEPTH - 1);

  phase_e        state_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] ir_q;
  logic [DW-1:0] ac_q;
  logic          out_valid_q;
  logic [DW-1:0] out_data_q;

  // decoded fields and named events
  op_e           op;
  logic [AW-1:0] addr;
  logic          in_exec;
  logic          reads_in;
  logic          stall;
  logic          exec_fire;
  logic          jump_taken;
  logic          out_hit;
  logic [DW-1:0] operand;
  logic          acc_we;
  logic [DW-1:0] acc_next;
  logic          acc_pos;
  logic [AW-1:0] pc_next;

  assign op        = op_e'(ir_q[DW-1:AW]);
  assign addr      = ir_q[AW-1:0];
  assign in_exec   = (state_q == ST_EXEC);
  assign reads_in  = reads_operand(op) && (addr == IN_ADDR);
  assign stall     = in_exec && reads_in && !in_valid;
  assign exec_fire = in_exec && !stall;
  assign operand   = reads_in ? in_data : mem_rdata;

  acc_alu #(.DW(DW)) u_alu (
    .op       (op),
    .acc      (ac_q),
    .operand  (operand),
    .acc_we   (acc_we),
    .acc_next (acc_next),
    .acc_pos  (acc_pos)
  );

  assign jump_taken = exec_fire &&
                      ((op == OP_JUMP) || ((op == OP_JPOS) && acc_pos));
  assign pc_next    = jump_taken ? addr : pc_q + 1'b1;
  assign out_hit    = exec_fire && (op == OP_STORE) && (addr == OUT_ADDR);

  assign mem_raddr = (state_q == ST_FETCH) ? pc_q : addr;
  assign mem_we    = exec_fire && (op == OP_STORE) && (addr != OUT_ADDR);
  assign mem_waddr = addr;
  assign mem_wdata = ac_q;
  assign in_ready  = exec_fire && reads_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_FETCH;
      pc_q        <= '0;
      ir_q        <= '0;
      ac_q        <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= out_hit;
      if (out_hit) out_data_q <= ac_q;
      unique case (state_q)
        ST_FETCH: begin
          ir_q    <= mem_rdata;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (exec_fire) begin
            if (op == OP_HALT) begin
              state_q <= ST_HALT;
            end else begin
              if (acc_we) ac_q <= acc_next;
              pc_q    <= pc_next;
              state_q <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign halted    = (state_q == ST_HALT);

  // R1
  fetch_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (state_q == ST_EXEC));
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && !jump_taken && op != OP_HALT) |=> (pc_q == AW'($past(pc_q) + 1)));
  // R6
  jpos_nonpos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && op == OP_JPOS && $signed(ac_q) <= 0) |=> (pc_q == AW'($past(pc_q) + 1)));
  // R7
  in_ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(pc_q) && $stable(ac_q) && state_q == ST_EXEC));
  // R8
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc_q) && $stable(ac_q) && $stable(ir_q) && !in_ready));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int unsigned DW = CPU_DW,
  parameter int unsigned AW = CPU_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          halted
);
  logic [AW-1:0] mem_raddr;
  logic [DW-1:0] mem_rdata;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  acc_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_addr (load_addr),
    .load_data (load_data),
    .cpu_we    (mem_we),
    .cpu_waddr (mem_waddr),
    .cpu_wdata (mem_wdata),
    .raddr     (mem_raddr),
    .rdata     (mem_rdata)
  );

  acc_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .mem_raddr (mem_raddr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .halted    (halted)
  );
endmodule

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;
  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 1'b0;
  logic [4:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       halted;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] prog [32];
  logic [7:0] outs [64];
  int out_cnt = 0;
  int taken_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .halted(halted)
  );

  // output and acceptance log, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && out_valid && out_cnt < 64) begin
      outs[out_cnt] = out_data;
      out_cnt++;
    end
    if (rst_n && in_ready) taken_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = 8'h00;
  endtask

  // R10: load under reset, then release
  task automatic boot();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) begin
      load_en = 1'b1; load_addr = 5'(i); load_data = prog[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    check("R10 halted clear in reset", int'(halted), 0);
    check("R10 out_valid clear in reset", int'(out_valid), 0);
    out_cnt = 0;
    taken_cnt = 0;
    rst_n = 1'b1;
  endtask

  task automatic give(input logic [7:0] v);
    logic ok;
    in_valid = 1'b1; in_data = v;
    do begin
      #1 ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic wait_halt(input int limit, output int edges);
    edges = 0;
    while (!halted && edges < limit) begin
      @(posedge clk); edges++;
      @(negedge clk);
    end
  endtask

  // console echo with wrap; includes an input stall window
  task automatic t_echo();
    int e;
    clear_prog();
    prog[0] = 8'h9E; prog[1] = 8'hBF; prog[2] = 8'hDE; prog[3] = 8'hBF;
    prog[4] = 8'hDE; prog[5] = 8'hBF; prog[6] = 8'h00;
    boot();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (in_ready || halted || out_cnt != 0) begin
        check("R7 stall without in_valid", 1, 0);
        break;
      end
    end
    check("R7 no progress while stalled", out_cnt, 0);
    give(8'd25); give(8'd50); give(8'd75);
    wait_halt(100, e);
    check("R8 echo count", out_cnt, 3);
    check("R8 first out", int'(outs[0]), 8'h19);
    check("R3 add 25+50", int'(outs[1]), 8'h4B);
    check("R3 wrap 75+75", int'(outs[2]), 8'h96);
    check("R7 inputs taken", taken_cnt, 3);
  endtask

  // positive-only loop on repeated 32
  task automatic t_jpos_loop();
    int e;
    clear_prog();
    prog[0] = 8'h9E; prog[1] = 8'hDE; prog[2] = 8'h41; prog[3] = 8'h00;
    boot();
    for (int i = 0; i < 4; i++) give(8'd32);
    wait_halt(20, e);
    check("R6 halt after -128", int'(halted), 1);
    check("R6 four inputs", taken_cnt, 4);
    in_valid = 1'b1; in_data = 8'd32;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (in_ready) begin check("R9 input after halt", 1, 0); break; end
    end
    in_valid = 1'b0;
    check("R9 still halted", int'(halted), 1);
    check("R9 no extra input", taken_cnt, 4);
    check("R9 no output", out_cnt, 0);
  endtask

  // powers of two with cycle count
  task automatic t_powers();
    int e;
    clear_prog();
    prog[0] = 8'h86; prog[1] = 8'hBF; prog[2] = 8'hA7; prog[3] = 8'hC7;
    prog[4] = 8'h41; prog[5] = 8'h00; prog[6] = 8'h01; prog[7] = 8'h00;
    boot();
    wait_halt(500, e);
    check("R1 edges to halt", e, 60);
    check("R4 output count", out_cnt, 7);
    for (int i = 0; i < 7; i++)
      check("R4 doubled value", int'(outs[i]), 1 << i);
  endtask

  // SUB, NOP, JUMP, fall-through and output cell kept
  task automatic t_misc();
    int e;
    clear_prog();
    prog[0] = 8'h8A; prog[1] = 8'hEB; prog[2] = 8'h49; prog[3] = 8'h60;
    prog[4] = 8'hBF; prog[5] = 8'hEC; prog[6] = 8'h49; prog[7] = 8'hBF;
    prog[8] = 8'h2D; prog[9] = 8'h00; prog[10] = 8'h05; prog[11] = 8'h05;
    prog[12] = 8'h03; prog[13] = 8'h9F; prog[14] = 8'hBF; prog[15] = 8'hB4;
    prog[16] = 8'h8C; prog[17] = 8'hD4; prog[18] = 8'hBF; prog[19] = 8'h00;
    prog[20] = 8'h00; prog[31] = 8'h2A;
    boot();
    wait_halt(200, e);
    check("R5 jump reached tail", out_cnt, 4);
    check("R6 zero falls through, R2 nop", int'(outs[0]), 8'h00);
    check("R3 sub wraps", int'(outs[1]), 8'hFD);
    check("R8 cell 31 kept", int'(outs[2]), 8'h2A);
    check("R4 store then reload", int'(outs[3]), 8'h2D);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_echo();
    t_jpos_loop();
    t_powers();
    t_misc();
    boot();
    @(posedge clk); @(negedge clk);
    check("R10 halted cleared by reset", int'(halted), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule